// File: doc/BRIEF.md
# Stereo Resampling Input FIFO

This block sits in front of a sample-rate conversion filter. It accepts left/right audio sample pairs at the input sample rate and writes each pair into two per-channel circular buffers. A downstream interpolation filter reads them back at its own pace. Before a sample is stored, its amplitude is adjusted twice. The first adjustment is a rate-ratio factor: it shrinks the sample when the output rate is below the input rate, so that the longer convolution used for downsampling cannot overflow. The second is a soft-mute gain that ramps gradually between silence and full scale.

The consumer moves a read pointer forward one word at a time and picks a word at a tap distance behind that pointer. After reset the write pointer stands a fixed guard distance ahead of the read pointer, so early reads of the newest taps never reach into the word being written. Both pointers run freely and wrap around the buffer.

The rate factor is an unsigned fixed-point value with 15 fraction bits, where 0x8000 means 1.0. The mute gain has 257 levels, from 0 to 256/256.

Top module: `stereo_rs_fifo`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets the read pointer to 0 and the write pointer to 64. It sets the mute gain to 0 if mute_req is high during reset, and to full scale (256) otherwise. In both cases mute_done reads 1 after reset.
- R2: Each clock edge with in_valid high writes the processed left and right samples at the write pointer and then advances that pointer by one. The first pair after reset therefore lands 64 words ahead of read pointer 0.
- R3: One clock edge after rd_tap is presented, rd_left and rd_right show the words stored at address (read pointer − rd_tap) mod 512. Each clock edge with rd_adv high advances the read pointer by one.
- R4: When ratio[15] is 1 (factor of 1.0 or more), the rate factor is unity and a sample at full gain is stored unchanged.
- R5: When ratio[15] is 0, the rate-scaled value is floor(sample × ratio / 32768 + 1/2), with samples as 24-bit two's complement.
- R6: The stored word is floor(r × g / 256 + 1/2), where r is the value from R4/R5 and g is the mute gain held before that sample's gain step. Each stage is saturated to the 24-bit signed range.
- R7: On each accepted sample, the gain falls by 1 (stopping at 0) while mute_req is high, and rises by 1 (stopping at 256) while mute_req is low. Without in_valid the gain does not change.
- R8: mute_done is 1 when mute_req is high and the gain is 0, or when mute_req is low and the gain is 256. Otherwise it is 0.
- R9: Both pointers and the tap subtraction wrap modulo 512, so after 448 writes following reset, the next sample is stored at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe: one stereo pair is present |
| in_left | input | 24 | Left sample, signed |
| in_right | input | 24 | Right sample, signed |
| ratio | input | 16 | Output/input rate factor, unsigned, 15 fraction bits |
| mute_req | input | 1 | 1 ramps toward silence, 0 ramps toward full scale |
| rd_adv | input | 1 | Advance the read pointer by one |
| rd_tap | input | 9 | Distance behind the read pointer to read |
| rd_left | output | 24 | Left word read, one cycle after the tap |
| rd_right | output | 24 | Right word read, one cycle after the tap |
| mute_done | output | 1 | The gain ramp has reached its requested endpoint |

## Verification
The hardest conditions to reach are the two ends of the mute ramp and pointer wrap. Each needs hundreds of accepted samples before it shows at the ports. The stimulus holds mute_req high and feeds a constant power-of-two sample for 257 samples, so each stored word reads back as the exact gain in force for that sample. mute_done is sampled on the pushes just before and just after the gain reaches zero. A separate run writes 450 numbered samples, so the write pointer passes address 511, and then reads across the wrap with taps that make the read subtraction underflow.

// File: rtl/srfifo_pkg.sv
package srfifo_pkg;
   localparam int NCH = 2;

   typedef enum logic [1:0] {
      RAMP_HOLD = 2'd0,
      RAMP_DOWN = 2'd1,
      RAMP_UP   = 2'd2
   } ramp_dir_e;
endpackage

// File: rtl/srfifo_gain_ramp.sv
module srfifo_gain_ramp
   import srfifo_pkg::*;
#(
   parameter int STEPS = 256
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    step,
   input  logic                    mute_req,
   output logic [$clog2(STEPS):0]  gain,
   output logic                    done
);
   localparam int GW = $clog2(STEPS) + 1;
   localparam logic [GW-1:0] FULL = GW'(STEPS);

   ramp_dir_e dir;

   always_comb begin
      dir = RAMP_HOLD;
      if (step) begin
         if (mute_req && gain != '0)
            dir = RAMP_DOWN;
         else if (!mute_req && gain != FULL)
            dir = RAMP_UP;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         gain <= mute_req ? '0 : FULL;
      end else begin
         case (dir)
            RAMP_DOWN: gain <= gain - 1'b1;
            RAMP_UP:   gain <= gain + 1'b1;
            default:   gain <= gain;
         endcase
      end
   end

   assign done = mute_req ? (gain == '0) : (gain == FULL);
endmodule

// File: rtl/srfifo_scaler.sv
module srfifo_scaler #(
   parameter int DW     = 24,
   parameter int KW     = 16,
   parameter int GSTEPS = 256
) (
   input  logic signed [DW-1:0]          din,
   input  logic        [KW-1:0]          ratio,
   input  logic        [$clog2(GSTEPS):0] gain,
   output logic signed [DW-1:0]          dout
);
   localparam int PW = DW + KW + 2;
   localparam int GS = $clog2(GSTEPS);
   localparam logic [KW:0] UNITY = (KW+1)'(1) << (KW-1);
   localparam logic signed [PW-1:0] HALF_K = PW'(1) <<< (KW-2);
   localparam logic signed [PW-1:0] HALF_G = PW'(GSTEPS / 2);
   localparam logic signed [PW-1:0] SMAX = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
   localparam logic signed [PW-1:0] SMIN = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

   function automatic logic signed [DW-1:0] clip(input logic signed [PW-1:0] v);
      if (v > SMAX)
         return SMAX[DW-1:0];
      else if (v < SMIN)
         return SMIN[DW-1:0];
      else
         return v[DW-1:0];
   endfunction

   logic        [KW:0]   keff;
   logic signed [PW-1:0] p_rate, r_rate, s_rate, p_gain, r_gain;

   always_comb begin
      // a factor of 1.0 or more means no downsampling: unity
      keff   = ratio[KW-1] ? UNITY : {1'b0, ratio};
      p_rate = PW'(din) * $signed({{(PW-KW-1){1'b0}}, keff});
      r_rate = (p_rate + HALF_K) >>> (KW-1);
      s_rate = PW'(clip(r_rate));
      p_gain = s_rate * $signed({{(PW-GS-1){1'b0}}, gain});
      r_gain = (p_gain + HALF_G) >>> GS;
      dout   = clip(r_gain);
   end
endmodule

// File: rtl/srfifo_ram.sv
module srfifo_ram #(
   parameter int DW = 24,
   parameter int AW = 9
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/stereo_rs_fifo.sv
module stereo_rs_fifo
   import srfifo_pkg::*;
#(
   parameter int DW     = 24,
   parameter int AW     = 9,
   parameter int GUARD  = 64,
   parameter int KW     = 16,
   parameter int GSTEPS = 256
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          in_valid,
   input  logic [DW-1:0] in_left,
   input  logic [DW-1:0] in_right,
   input  logic [KW-1:0] ratio,
   input  logic          mute_req,
   input  logic          rd_adv,
   input  logic [AW-1:0] rd_tap,
   output logic [DW-1:0] rd_left,
   output logic [DW-1:0] rd_right,
   output logic          mute_done
);
   localparam int DEPTH = 1 << AW;
   localparam int GWID  = $clog2(GSTEPS) + 1;

   if (GUARD <= 0 || GUARD >= DEPTH) begin : g_bad_guard
      $error("GUARD must lie between 1 and DEPTH-1");
   end
   if (GSTEPS < 2 || (GSTEPS & (GSTEPS - 1)) != 0) begin : g_bad_steps
      $error("GSTEPS must be a power of two of at least 2");
   end
   if (KW < 2 || DW < 2) begin : g_bad_width
      $error("KW and DW must be at least 2");
   end

   logic [AW-1:0]   wr_ptr_q, rd_ptr_q, rd_addr;
   logic [GWID-1:0] gain_w;

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr_q <= AW'(GUARD);
         rd_ptr_q <= '0;
      end else begin
         if (in_valid) wr_ptr_q <= wr_ptr_q + 1'b1;
         if (rd_adv)   rd_ptr_q <= rd_ptr_q + 1'b1;
      end
   end

   assign rd_addr = rd_ptr_q - rd_tap;

   srfifo_gain_ramp #(.STEPS(GSTEPS)) u_ramp (
      .clk      (clk),
      .rst      (rst),
      .step     (in_valid),
      .mute_req (mute_req),
      .gain     (gain_w),
      .done     (mute_done)
   );

   logic        [DW-1:0] ch_in  [NCH];
   logic signed [DW-1:0] ch_wr  [NCH];
   logic        [DW-1:0] ch_out [NCH];

   assign ch_in[0] = in_left;
   assign ch_in[1] = in_right;

   for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
      srfifo_scaler #(.DW(DW), .KW(KW), .GSTEPS(GSTEPS)) u_scale (
         .din   ($signed(ch_in[ch])),
         .ratio (ratio),
         .gain  (gain_w),
         .dout  (ch_wr[ch])
      );

      srfifo_ram #(.DW(DW), .AW(AW)) u_ram (
         .clk   (clk),
         .we    (in_valid),
         .waddr (wr_ptr_q),
         .wdata (ch_wr[ch]),
         .raddr (rd_addr),
         .rdata (ch_out[ch])
      );
   end

   assign rd_left  = ch_out[0];
   assign rd_right = ch_out[1];
endmodule

// File: rtl/srfifo_chk.sv
module srfifo_chk #(
   parameter int AW     = 9,
   parameter int GUARD  = 64,
   parameter int GSTEPS = 256
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     in_valid,
   input logic                     rd_adv,
   input logic                     mute_req,
   input logic                     mute_done,
   input logic [AW-1:0]            wr_ptr,
   input logic [AW-1:0]            rd_ptr,
   input logic [$clog2(GSTEPS):0]  gain
);
   localparam int GW = $clog2(GSTEPS) + 1;
   localparam logic [GW-1:0] FULL = GW'(GSTEPS);

   AST_RESET_PTRS: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (wr_ptr == AW'(GUARD) && rd_ptr == '0)); // R1
   AST_WR_STEP: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> wr_ptr == $past(wr_ptr) + 1'b1); // R2
   AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(wr_ptr)); // R2
   AST_RD_STEP: assert property (@(posedge clk) disable iff (rst)
      rd_adv |=> rd_ptr == $past(rd_ptr) + 1'b1); // R3
   AST_GAIN_MAX: assert property (@(posedge clk) disable iff (rst)
      gain <= FULL); // R7
   AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(gain)); // R7
   AST_GAIN_DOWN: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mute_req && gain != '0) |=> gain == $past(gain) - 1'b1); // R7
   AST_DONE_STAYS: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mute_req && mute_done) |=> gain == '0); // R8
endmodule

bind stereo_rs_fifo srfifo_chk #(.AW(AW), .GUARD(GUARD), .GSTEPS(GSTEPS)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .rd_adv    (rd_adv),
   .mute_req  (mute_req),
   .mute_done (mute_done),
   .wr_ptr    (wr_ptr_q),
   .rd_ptr    (rd_ptr_q),
   .gain      (gain_w)
);

// File: tb/tb_stereo_rs_fifo.sv
module tb_stereo_rs_fifo;
   logic        clk = 1'b0;
   logic        rst, in_valid, mute_req, rd_adv;
   logic [23:0] in_left, in_right, rd_left, rd_right;
   logic [15:0] ratio;
   logic [8:0]  rd_tap;
   logic        mute_done;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   stereo_rs_fifo dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_left(in_left),
      .in_right(in_right), .ratio(ratio), .mute_req(mute_req),
      .rd_adv(rd_adv), .rd_tap(rd_tap), .rd_left(rd_left),
      .rd_right(rd_right), .mute_done(mute_done)
   );

   // {ratio, left in, right in, left expected, right expected}
   localparam int NV = 7;
   localparam logic [111:0] VEC [NV] = '{
      {16'h8000, 24'h123456, 24'hFEDCBA, 24'h123456, 24'hFEDCBA},
      {16'hC000, 24'hFFFFFB, 24'h000007, 24'hFFFFFB, 24'h000007},
      {16'h4000, 24'h000064, 24'h000065, 24'h000032, 24'h000033},
      {16'h4000, 24'h7FFFFF, 24'h800000, 24'h400000, 24'hC00000},
      {16'h0000, 24'h0004D2, 24'hFFFB2E, 24'h000000, 24'h000000},
      {16'h7FFF, 24'h7FFFFF, 24'h800000, 24'h7FFEFF, 24'h800100},
      {16'h2000, 24'h000006, 24'hFFFFFA, 24'h000002, 24'hFFFFFF}
   };

   task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   task automatic do_reset(input logic m);
      @(negedge clk);
      rst = 1'b1; mute_req = m; in_valid = 1'b0; rd_adv = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic push(input logic [23:0] l, input logic [23:0] r);
      @(negedge clk);
      in_valid = 1'b1; in_left = l; in_right = r;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic read_at(input logic [8:0] tap, output logic [23:0] l, output logic [23:0] r);
      @(negedge clk);
      rd_tap = tap;
      @(negedge clk);
      l = rd_left; r = rd_right;
   endtask

   task automatic advance(input int n);
      @(negedge clk);
      rd_adv = 1'b1;
      repeat (n) @(negedge clk);
      rd_adv = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL R2 watchdog: actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [23:0] l, r;
      int          e;
      rst = 1'b1; in_valid = 1'b0; mute_req = 1'b0; rd_adv = 1'b0;
      in_left = '0; in_right = '0; ratio = 16'h8000; rd_tap = '0;

      // reset state, unmuted
      do_reset(1'b0);
      check("R1 mute_done after reset unmuted", 24'(mute_done), 24'h1);
      check("R8 done at full gain", 24'(mute_done), 24'h1);

      // vector table: rate scaling at full gain
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         ratio = VEC[i][111:96];
         push(VEC[i][95:72], VEC[i][71:48]);
      end
      for (int i = 0; i < NV; i++) begin
         read_at(9'(448 - i), l, r);
         if (VEC[i][111]) begin
            check("R4 unity left", l, VEC[i][47:24]);
            check("R4 unity right", r, VEC[i][23:0]);
         end else begin
            check("R5 scaled left", l, VEC[i][47:24]);
            check("R5 scaled right", r, VEC[i][23:0]);
         end
      end

      // guard offset and read pointer advance
      do_reset(1'b0);
      ratio = 16'h8000;
      push(24'h0A0A0A, 24'h050505);
      push(24'h0B0B0B, 24'h060606);
      advance(64);
      read_at(9'd0, l, r);
      check("R2 first sample at guard left", l, 24'h0A0A0A);
      check("R3 advanced pointer right", r, 24'h050505);
      read_at(9'd511, l, r);
      check("R3 tap underflow reads next word", l, 24'h0B0B0B);

      // pointer wrap
      do_reset(1'b0);
      for (int n = 0; n < 450; n++) push(24'(n), 24'h800000 | 24'(n));
      read_at(9'd511, l, r);
      check("R9 wrapped write left", l, 24'd449);
      check("R9 wrapped write right", r, 24'h8001C1);
      read_at(9'd1, l, r);
      check("R9 last word before wrap", l, 24'd447);

      // mute ramp down
      do_reset(1'b0);
      @(negedge clk);
      mute_req = 1'b1;
      @(negedge clk);
      check("R8 done low while ramp pending", 24'(mute_done), 24'h0);
      repeat (5) @(negedge clk);
      for (int k = 0; k <= 256; k++) begin
         push(24'h010000, 24'hFF0000);
         if (k == 254) check("R8 done low one step before zero", 24'(mute_done), 24'h0);
         if (k == 255) check("R8 done high at zero gain", 24'(mute_done), 24'h1);
      end
      foreach (VEC[q]) begin end
      for (int j = 0; j < 5; j++) begin
         int k;
         k = (j == 0) ? 0 : (j == 1) ? 1 : (j == 2) ? 128 : (j == 3) ? 255 : 256;
         e = 256 * (256 - k);
         read_at(9'(448 - k), l, r);
         check("R7 ramp down left", l, 24'(e));
         check("R6 gain applied right", r, 24'(-e));
      end

      // mute release: ramp up
      @(negedge clk);
      mute_req = 1'b0;
      @(negedge clk);
      check("R8 done low after release", 24'(mute_done), 24'h0);
      push(24'h010000, 24'h010000);
      push(24'h010000, 24'h010000);
      push(24'h000040, 24'hFFFFC0);
      read_at(9'd191, l, r);
      check("R7 first sample after release at zero gain", l, 24'h000000);
      read_at(9'd190, l, r);
      check("R7 ramp up one step", l, 24'h000100);
      read_at(9'd189, l, r);
      check("R6 half rounds up left", l, 24'h000001);
      check("R6 negative half rounds up right", r, 24'h000000);

      // reset while mute requested
      do_reset(1'b1);
      check("R1 mute_done after reset muted", 24'(mute_done), 24'h1);
      push(24'h100000, 24'h100000);
      read_at(9'd448, l, r);
      check("R1 zero gain after muted reset", l, 24'h000000);

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule